// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit binary adder. It takes two operands and a carry-in and returns the 16-bit sum and the carry-out in the same cycle. No carry ripples from one bit position to the next. Every bit position derives a generate term (both operand bits set) and a propagate term (either operand bit set). The bits are split into four 4-bit slices.

Each slice works out its internal carries with flattened lookahead equations. It also summarises itself as a slice propagate and a slice generate. A second lookahead stage combines the four slice summaries with the external carry-in and produces the carry into each slice and the final carry-out.

The slice propagate and generate vectors are brought out as ports. A wider adder can then use them as the first level of a deeper lookahead tree. The block has no clock, no reset and no state. The house state-machine pattern therefore reduces to named combinational stages: bit terms, slice lookahead and second-level lookahead.

Top module: `cla2_adder16`

## Requirements
- R1: `sum` equals the low 16 bits of `op_a + op_b + carry_in` for every input combination.
- R2: `carry_out` equals bit 16 of `op_a + op_b + carry_in`.
- R3: Slice k covers operand bits 4k+3 down to 4k. `slice_gen[k]` is 1 exactly when the 4-bit sum of that slice of `op_a` and `op_b` exceeds 15 with a zero carry into the slice.
- R4: `slice_prop[k]` is 1 exactly when every bit position of slice k has at least one operand bit set.
- R5: The carry entering slice k (k = 1..3) equals the true arithmetic carry out of bits 4k-1..0 including `carry_in`. It is therefore visible through `sum` bit 4k.
- R6: When a slice propagates and does not generate, its carry-out equals its carry-in. With every slice in that condition, `carry_out` equals `carry_in`.
- R7: `slice_prop` and `slice_gen` do not depend on `carry_in`. Toggling `carry_in` with fixed operands leaves both vectors unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| slice_prop | output | 4 | Per-slice propagate, bit k for operand bits 4k+3..4k |
| slice_gen | output | 4 | Per-slice generate, bit k for operand bits 4k+3..4k |

## Verification
Every output is combinational, so each result is due in the same cycle its operands are applied, with zero register stages. The driver changes the operands just after a rising edge and queues the expected sum, carry-out and slice vectors. The monitor pops and compares them at the following falling edge, half a period later. By then the operands have been stable for the whole settling window and no new stimulus has started. R7 is covered by applying each operand pair with both carry-in values and expecting identical slice vectors.

// File: rtl/cla2_pkg.sv
package cla2_pkg;
    localparam int ADD_WIDTH_DEF = 16;
    localparam int SLICE_W_DEF   = 4;
endpackage

// File: rtl/cla2_bit_terms.sv
module cla2_bit_terms #(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] gen,
    output logic [N-1:0] prop
);
    // Stage 1: per-bit generate and propagate (propagate uses OR form)
    always_comb begin
        for (int i = 0; i < N; i++) begin
            gen[i]  = a[i] & b[i];
            prop[i] = a[i] | b[i];
        end
    end
endmodule

// File: rtl/cla2_carry_net.sv
module cla2_carry_net #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prop,
    input  logic         cin,
    output logic [N:0]   carry
);
    // Flattened sum-of-products: every carry is built directly from the
    // generate/propagate terms and cin, never from a lower computed carry.
    always_comb begin
        logic acc;
        logic term;
        carry[0] = cin;
        for (int j = 0; j < N; j++) begin
            acc = 1'b0;
            for (int k = -1; k <= j; k++) begin
                term = (k < 0) ? cin : gen[k];
                for (int m = k + 1; m <= j; m++) begin
                    term = term & prop[m];
                end
                acc = acc | term;
            end
            carry[j+1] = acc;
        end
    end

    // The flat form must agree with the recursive carry rule at every bit
    always_comb begin
        for (int j = 0; j < N; j++) begin
            AST_CARRY_RULE: assert (carry[j+1] == (gen[j] | (prop[j] & carry[j])))
                else $error("carry rule broken at position %0d", j); // R5
        end
    end
endmodule

// File: rtl/cla2_slice_summary.sv
module cla2_slice_summary #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prop,
    output logic         s_prop,
    output logic         s_gen
);
    always_comb begin
        logic term;
        s_prop = &prop;
        s_gen  = 1'b0;
        for (int k = 0; k < N; k++) begin
            term = gen[k];
            for (int m = k + 1; m < N; m++) begin
                term = term & prop[m];
            end
            s_gen = s_gen | term;
        end
    end
endmodule

// File: rtl/cla2_slice.sv
module cla2_slice #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         sp,
    output logic         sg
);
    localparam int EW = W + 1;

    logic [W-1:0] gen;
    logic [W-1:0] prop;
    logic [W:0]   carry;
    logic [W:0]   chk_total;
    logic [W:0]   chk_nocin;

    cla2_bit_terms #(.N(W)) u_terms (
        .a    (a),
        .b    (b),
        .gen  (gen),
        .prop (prop)
    );

    cla2_carry_net #(.N(W)) u_carry (
        .gen   (gen),
        .prop  (prop),
        .cin   (ci),
        .carry (carry)
    );

    cla2_slice_summary #(.N(W)) u_summary (
        .gen    (gen),
        .prop   (prop),
        .s_prop (sp),
        .s_gen  (sg)
    );

    assign s = a ^ b ^ carry[W-1:0];

    always_comb begin
        chk_total = {1'b0, a} + {1'b0, b} + EW'(ci);
        chk_nocin = {1'b0, a} + {1'b0, b};
        AST_SLICE_SUM: assert ({carry[W], s} == chk_total)
            else $error("slice sum mismatch"); // R1
        AST_SLICE_GEN: assert (sg == chk_nocin[W])
            else $error("slice generate mismatch"); // R3
        if (sp && !sg) begin
            AST_SLICE_PASS: assert (carry[W] == ci)
                else $error("propagating slice did not pass carry"); // R6
        end
    end
endmodule

// File: rtl/cla2_adder16.sv
module cla2_adder16
    import cla2_pkg::*;
#(
    parameter int WIDTH   = ADD_WIDTH_DEF,
    parameter int SLICE_W = SLICE_W_DEF
) (
    input  logic [WIDTH-1:0]           op_a,
    input  logic [WIDTH-1:0]           op_b,
    input  logic                       carry_in,
    output logic [WIDTH-1:0]           sum,
    output logic                       carry_out,
    output logic [WIDTH/SLICE_W-1:0]   slice_prop,
    output logic [WIDTH/SLICE_W-1:0]   slice_gen
);
    localparam int NSL = WIDTH / SLICE_W;
    localparam int FW  = WIDTH + 1;

    logic [NSL:0]   slice_cin;
    logic [WIDTH:0] chk_full;

    // Stage 3: second-level lookahead over the slice summaries
    cla2_carry_net #(.N(NSL)) u_level2 (
        .gen   (slice_gen),
        .prop  (slice_prop),
        .cin   (carry_in),
        .carry (slice_cin)
    );

    // Stage 2: one lookahead slice per group of SLICE_W bits
    for (genvar k = 0; k < NSL; k++) begin : g_slice
        cla2_slice #(.W(SLICE_W)) u_sl (
            .a  (op_a[k*SLICE_W +: SLICE_W]),
            .b  (op_b[k*SLICE_W +: SLICE_W]),
            .ci (slice_cin[k]),
            .s  (sum[k*SLICE_W +: SLICE_W]),
            .sp (slice_prop[k]),
            .sg (slice_gen[k])
        );
    end

    assign carry_out = slice_cin[NSL];

    always_comb begin
        chk_full = {1'b0, op_a} + {1'b0, op_b} + FW'(carry_in);
        AST_TOP_SUM: assert (sum == chk_full[WIDTH-1:0])
            else $error("sum mismatch"); // R1
        AST_TOP_COUT: assert (carry_out == chk_full[WIDTH])
            else $error("carry-out mismatch"); // R2
        for (int k = 1; k < NSL; k++) begin
            AST_SLICE_ENTRY: assert (slice_cin[k] ==
                    (chk_full[k*SLICE_W] ^ op_a[k*SLICE_W] ^ op_b[k*SLICE_W]))
                else $error("carry into slice %0d wrong", k); // R5
        end
        if ((&slice_prop) && !(|slice_gen)) begin
            AST_ALL_PASS: assert (carry_out == carry_in)
                else $error("full propagate did not pass carry-in"); // R6
        end
    end
endmodule

// File: tb/sim_cla2_adder16.sv
module sim_cla2_adder16;
    typedef struct {
        logic [15:0] a;
        logic [15:0] b;
        logic        ci;
        logic [15:0] s;
        logic        co;
        logic [3:0]  p;
        logic [3:0]  g;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum;
    logic        carry_out;
    logic [3:0]  slice_prop;
    logic [3:0]  slice_gen;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    cla2_adder16 u0 (
        .op_a       (op_a),
        .op_b       (op_b),
        .carry_in   (carry_in),
        .sum        (sum),
        .carry_out  (carry_out),
        .slice_prop (slice_prop),
        .slice_gen  (slice_gen)
    );

    function automatic exp_t model(logic [15:0] a, logic [15:0] b, logic ci);
        exp_t e;
        logic [16:0] full;
        logic [4:0]  part;
        full = {1'b0, a} + {1'b0, b} + {16'd0, ci};
        e.a = a; e.b = b; e.ci = ci;
        e.s  = full[15:0];
        e.co = full[16];
        for (int k = 0; k < 4; k++) begin
            part   = {1'b0, a[k*4 +: 4]} + {1'b0, b[k*4 +: 4]};
            e.g[k] = part[4];
            e.p[k] = &(a[k*4 +: 4] | b[k*4 +: 4]);
        end
        return e;
    endfunction

    // Driver: change inputs just after a rising edge, queue the expectation
    task automatic drive(logic [15:0] a, logic [15:0] b, logic ci);
        @(posedge clk);
        op_a     <= a;
        op_b     <= b;
        carry_in <= ci;
        exp_q.push_back(model(a, b, ci));
    endtask

    // R7: same operands with both carry-in values; model slice vectors ignore ci
    task automatic drive_both(logic [15:0] a, logic [15:0] b);
        drive(a, b, 1'b0);
        drive(a, b, 1'b1);
    endtask

    // Monitor: zero-latency results compared at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (sum !== e.s) begin
                n_fail++;
                $display("FAIL R1/R5 sum a=%h b=%h ci=%0d: got %h exp %h", e.a, e.b, e.ci, sum, e.s);
            end
            if (carry_out !== e.co) begin
                n_fail++;
                $display("FAIL R2/R6 carry_out a=%h b=%h ci=%0d: got %0d exp %0d", e.a, e.b, e.ci, carry_out, e.co);
            end
            if (slice_gen !== e.g) begin
                n_fail++;
                $display("FAIL R3/R7 slice_gen a=%h b=%h ci=%0d: got %b exp %b", e.a, e.b, e.ci, slice_gen, e.g);
            end
            if (slice_prop !== e.p) begin
                n_fail++;
                $display("FAIL R4/R7 slice_prop a=%h b=%h ci=%0d: got %b exp %b", e.a, e.b, e.ci, slice_prop, e.p);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1 R2: idle state with all-zero inputs
        drive(16'h0000, 16'h0000, 1'b0);
        // R6: full propagate, no generate -> carry_out follows carry_in
        drive_both(16'hFFFF, 16'h0000);
        drive_both(16'hAAAA, 16'h5555);
        // R5: carry crossing each slice boundary
        drive_both(16'h000F, 16'h0001);
        drive_both(16'h00FF, 16'h0001);
        drive_both(16'h0FFF, 16'h0001);
        drive(16'h0FFF, 16'h0000, 1'b1);
        // R2: overflow and maximum operands
        drive_both(16'hFFFF, 16'hFFFF);
        drive_both(16'h8000, 16'h8000);
        // R3 R4: generate without full propagate in each slice
        drive_both(16'h8888, 16'h8888);
        drive_both(16'h7777, 16'h0000);
        drive_both(16'h1248, 16'h8421);
        // R1 R5: exhaustive low 7x7 bits with both carry-ins, fixed upper fields
        for (int x = 0; x < 128; x++) begin
            for (int y = 0; y < 128; y++) begin
                drive_both(16'h3C00 | 16'(x), 16'hC380 | 16'(y));
            end
        end
        // R1..R7: random operands
        for (int r = 0; r < 2000; r++) begin
            drive_both(16'($urandom), 16'($urandom));
        end
        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule